// File: doc/BRIEF.md
# Dual-Bank Concurrent SRAM Interconnect

This block is a small on-chip memory made of two SRAM banks placed back to back in one address window that starts at 0x2000_0000. Two masters reach it: a CPU port and a DMA port. Each port has a request, write enable, address, write data and access size, and returns ready, a fault flag and read data. Either port can reach either bank. When the two ports address different banks, both accesses are served in the same cycle.

When both ports want the same bank in the same cycle, a fixed-priority arbiter serves the CPU. The DMA port sees ready low and keeps its request up. Its access completes in the first cycle in which the CPU is not using that bank. An access that meets no contention completes in the cycle it is presented, so there are no wait states. Read data follows in the next cycle.

Accesses are 8, 16 or 32 bits wide. The low two address bits select the byte lanes. A write touches only the lanes it selects. A request that is misaligned, that uses the reserved size code, or that falls outside the window is flagged and dropped.

Top module: `dual_bank_sram`

## Requirements
- R1: A byte offset (address minus 0x2000_0000) below BANK0_BYTES selects bank A. An offset from BANK0_BYTES up to BANK0_BYTES+BANK1_BYTES selects bank B. Any other address is flagged as a fault.
- R2: The size codes are 0 for byte, 1 for half-word and 2 for word. A byte write updates lane addr[1:0]. A half-word write updates lanes addr[1:0] and addr[1:0]+1. A word write updates all four lanes. Lane n is data bits 8n+7 to 8n.
- R3: A faulted request has fault=1 and ready=1 in the cycle it is presented. It changes no memory, claims no bank, and returns zero read data. A faulted request is one of: a half-word at an odd address, a word whose addr[1:0] is not 0, size code 3, or an address outside the window.
- R4: A CPU request always gets ready in the cycle it is presented. A DMA request also gets ready in that cycle unless it collides with the CPU on the same bank.
- R5: Valid requests from both ports to different banks both get ready in the same cycle, and both take effect.
- R6: When both ports make valid requests to the same bank, the CPU is served and DMA ready stays low. The held DMA request completes in the first cycle the CPU leaves that bank.
- R7: Read data for an accepted read appears in the cycle after acceptance. Each addressed byte sits in the lane that matches its address, and lanes outside the access read as zero.
- R8: Read data is zero in every cycle that does not follow an accepted, unfaulted read. While reset is low, ready and fault are low and nothing is written.
- R9: Each port can write and read back both banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write enable (1 = write) |
| cpu_size | input | 2 | CPU access size code |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 32 | CPU write data, lane aligned |
| cpu_ready | output | 1 | CPU access completes this cycle |
| cpu_fault | output | 1 | CPU request rejected |
| cpu_rdata | output | 32 | CPU read data, cycle after acceptance |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write enable |
| dma_size | input | 2 | DMA access size code |
| dma_addr | input | ADDR_W | DMA byte address |
| dma_wdata | input | 32 | DMA write data, lane aligned |
| dma_ready | output | 1 | DMA access completes this cycle |
| dma_fault | output | 1 | DMA request rejected |
| dma_rdata | output | 32 | DMA read data, cycle after acceptance |

## Verification
The embedded properties check on every cycle that the CPU never waits. They also check that a split-bank pair is always served together, that a same-bank pair always stalls the DMA side, that only lane-shaped strobes reach a bank, and that read data stays zero after any cycle without an accepted read. The stimulus scenarios cover the rest: lane merging in memory and lane placement on readback, the rule that faulted writes leave memory untouched, the point at which a held DMA request finally lands, and decoding at the edges of both banks and of the window.

// File: rtl/dbsram_pkg.sv
// Shared definitions for the dual-bank SRAM interconnect.
// Assumes a 32-bit data path split into four byte lanes.
package dbsram_pkg;
    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/dbsram_port_decode.sv
// Decodes one master's request.
// Produces the bank select, the word index inside that bank and the byte strobes.
// Flags requests that are misaligned, use the reserved size, or fall outside the window.
// Assumes BASE and BANK0_BYTES are multiples of 4.
module dbsram_port_decode #(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BASE        = 32'h2000_0000,
    parameter int          BANK0_BYTES = 256,
    parameter int          BANK1_BYTES = 128,
    parameter int          IDX_W       = 6
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              valid,
    output logic              fault,
    output logic              bank,
    output logic [IDX_W-1:0]  idx,
    output logic [3:0]        be
);
    import dbsram_pkg::*;

    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(BANK0_BYTES + BANK1_BYTES);
    localparam logic [ADDR_W-1:0] SPLIT  = ADDR_W'(BANK0_BYTES);
    localparam logic [IDX_W-1:0]  B0_WDS = IDX_W'(BANK0_BYTES / 4);

    logic [ADDR_W-1:0] offset;
    logic              in_win;
    logic              aligned;
    acc_size_e         sz;

    // Offset into the window, window hit and bank split.
    always_comb begin
        offset = addr - BASE[ADDR_W-1:0];
        in_win = offset < SPAN;
        bank   = offset >= SPLIT;
        idx    = offset[IDX_W+1:2] - (bank ? B0_WDS : '0);
    end

    // Alignment check and byte-strobe pattern from size and low offset bits.
    always_comb begin
        sz = acc_size_e'(size);
        unique case (sz)
            SZ_BYTE: begin aligned = 1'b1;             be = 4'b0001 << offset[1:0]; end
            SZ_HALF: begin aligned = ~offset[0];       be = 4'b0011 << offset[1:0]; end
            SZ_WORD: begin aligned = offset[1:0] == 0; be = 4'b1111;                end
            default: begin aligned = 1'b0;             be = 4'b0000;                end
        endcase
        valid = req & in_win & aligned;
        fault = req & ~(in_win & aligned);
    end
endmodule

// File: rtl/dbsram_bank_arb.sv
// Fixed-priority arbiter for one bank.
// The CPU port always wins. The DMA port is granted only when the CPU is not on this bank.
module dbsram_bank_arb #(
    parameter bit BANK_ID = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_valid,
    input  logic cpu_bank,
    input  logic dma_valid,
    input  logic dma_bank,
    output logic gnt_cpu,
    output logic gnt_dma
);
    logic hit_cpu, hit_dma;

    // Bank hits and the priority decision.
    always_comb begin
        hit_cpu = cpu_valid && (cpu_bank == BANK_ID);
        hit_dma = dma_valid && (dma_bank == BANK_ID);
        gnt_cpu = hit_cpu;
        gnt_dma = hit_dma && !hit_cpu;
    end

    // R6: a DMA request on this bank is granted exactly when the CPU is absent from it.
    p_dma_yields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && dma_bank == BANK_ID) |-> (gnt_dma != (cpu_valid && cpu_bank == BANK_ID)));
endmodule

// File: rtl/dbsram_bank.sv
// One single-port SRAM bank with per-lane write strobes and a registered read word.
// Assumes idx is below WORDS whenever en is high. Memory contents are not reset.
module dbsram_bank #(
    parameter int WORDS = 64,
    localparam int BIDX = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            we,
    input  logic [BIDX-1:0] idx,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    output logic [31:0]     q
);
    logic [31:0] mem [WORDS];

    // Strobed lane writes and the registered read word.
    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int l = 0; l < 4; l++) begin
                if (be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
            end
        end
        if (en && !we) q <= mem[idx];
    end

    // R2: a write reaches the bank only with a byte, half-word or word lane shape.
    p_lane_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |-> (be == 4'b0001 || be == 4'b0010 || be == 4'b0100 || be == 4'b1000 ||
                        be == 4'b0011 || be == 4'b1100 || be == 4'b1111));
endmodule

// File: rtl/dual_bank_sram.sv
// Two-bank SRAM shared by a CPU port and a DMA port.
// Each bank has its own arbiter, so the two ports run in parallel on different banks.
// Uncontended accesses complete in the cycle they are presented.
// Read data returns one cycle later, masked to the addressed lanes.
// Assumes a masters holds a request steady until ready.
module dual_bank_sram #(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BASE        = 32'h2000_0000,
    parameter int          BANK0_BYTES = 256,
    parameter int          BANK1_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_fault,
    output logic [31:0]       cpu_rdata,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [1:0]        dma_size,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [31:0]       dma_wdata,
    output logic              dma_ready,
    output logic              dma_fault,
    output logic [31:0]       dma_rdata
);
    localparam int NPORT  = 2;
    localparam int W0     = BANK0_BYTES / 4;
    localparam int W1     = BANK1_BYTES / 4;
    localparam int WMAX   = (W0 > W1) ? W0 : W1;
    localparam int IDX_W  = (WMAX > 1) ? $clog2(WMAX) : 1;

    logic              p_req   [NPORT];
    logic              p_we    [NPORT];
    logic [1:0]        p_size  [NPORT];
    logic [ADDR_W-1:0] p_addr  [NPORT];
    logic [31:0]       p_wdata [NPORT];
    logic              p_valid [NPORT];
    logic              p_fault [NPORT];
    logic              p_bank  [NPORT];
    logic [IDX_W-1:0]  p_idx   [NPORT];
    logic [3:0]        p_be    [NPORT];
    logic              p_gnt   [NPORT];
    logic              p_ready [NPORT];
    logic [31:0]       p_rdata [NPORT];

    logic              rd_valid [NPORT];
    logic              rd_bank  [NPORT];
    logic [3:0]        rd_be    [NPORT];

    logic        b_gc [2];
    logic        b_gd [2];
    logic [31:0] b_q  [2];

    // Gather the two masters into port-indexed arrays; reset masks requests.
    always_comb begin
        p_req[0] = cpu_req & rst_n;  p_we[0] = cpu_we;  p_size[0] = cpu_size;
        p_addr[0] = cpu_addr;        p_wdata[0] = cpu_wdata;
        p_req[1] = dma_req & rst_n;  p_we[1] = dma_we;  p_size[1] = dma_size;
        p_addr[1] = dma_addr;        p_wdata[1] = dma_wdata;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dbsram_port_decode #(
            .ADDR_W(ADDR_W), .BASE(BASE), .BANK0_BYTES(BANK0_BYTES),
            .BANK1_BYTES(BANK1_BYTES), .IDX_W(IDX_W)
        ) u_dec (
            .req(p_req[p]), .addr(p_addr[p]), .size(p_size[p]),
            .valid(p_valid[p]), .fault(p_fault[p]), .bank(p_bank[p]),
            .idx(p_idx[p]), .be(p_be[p])
        );

        // Completion: a faulted request is dropped at once; a valid one needs its grant.
        always_comb begin
            p_gnt[p]   = (p == 0) ? (b_gc[0] | b_gc[1]) : (b_gd[0] | b_gd[1]);
            p_ready[p] = p_fault[p] | (p_valid[p] & p_gnt[p]);
        end

        // Remember an accepted read so its data can be steered next cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_valid[p] <= 1'b0;
                rd_bank[p]  <= 1'b0;
                rd_be[p]    <= 4'b0000;
            end else begin
                rd_valid[p] <= p_valid[p] & p_gnt[p] & ~p_we[p];
                rd_bank[p]  <= p_bank[p];
                rd_be[p]    <= p_be[p];
            end
        end

        // Return the bank word with lanes outside the access forced to zero.
        always_comb begin
            for (int l = 0; l < 4; l++) begin
                p_rdata[p][8*l +: 8] = (rd_valid[p] && rd_be[p][l])
                                       ? b_q[rd_bank[p]][8*l +: 8] : 8'h00;
            end
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam int WB   = (b == 0) ? W0 : W1;
        localparam int BIDX = (WB > 1) ? $clog2(WB) : 1;
        logic sel;

        dbsram_bank_arb #(.BANK_ID(b[0])) u_arb (
            .clk(clk), .rst_n(rst_n),
            .cpu_valid(p_valid[0]), .cpu_bank(p_bank[0]),
            .dma_valid(p_valid[1]), .dma_bank(p_bank[1]),
            .gnt_cpu(b_gc[b]), .gnt_dma(b_gd[b])
        );

        // Pick the granted port's controls for this bank.
        always_comb sel = b_gd[b];

        dbsram_bank #(.WORDS(WB)) u_mem (
            .clk(clk), .rst_n(rst_n),
            .en(b_gc[b] | b_gd[b]),
            .we(p_we[sel]),
            .idx(p_idx[sel][BIDX-1:0]),
            .be(p_be[sel]),
            .wdata(p_wdata[sel]),
            .q(b_q[b])
        );
    end

    // Drive the master-facing outputs.
    always_comb begin
        cpu_ready = p_ready[0];  cpu_fault = p_fault[0];  cpu_rdata = p_rdata[0];
        dma_ready = p_ready[1];  dma_fault = p_fault[1];  dma_rdata = p_rdata[1];
    end

    // R4: the CPU never waits.
    p_cpu_no_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> cpu_ready);

    // R5: valid requests to different banks are served together.
    p_split_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid[0] && p_valid[1] && p_bank[0] != p_bank[1]) |-> (cpu_ready && dma_ready));

    // R6: on a same-bank pair the CPU completes and the DMA port is held.
    p_cpu_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid[0] && p_valid[1] && p_bank[0] == p_bank[1]) |-> (cpu_ready && !dma_ready));

    // R8: read data stays zero unless an unfaulted read was accepted one cycle earlier.
    p_cpu_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_req && cpu_ready && !cpu_we && !cpu_fault) |-> (cpu_rdata == 32'h0));
    p_dma_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dma_req && dma_ready && !dma_we && !dma_fault) |-> (dma_rdata == 32'h0));
endmodule

// File: tb/test_dual_bank_sram.sv
// Self-checking bench for dual_bank_sram.
// A table of per-cycle stimulus with expected ready and fault bits is walked first.
// A byte model of the memory predicts the read data. Directed tests then cover reset and stalls.
module test_dual_bank_sram;
    localparam logic [31:0] A0 = 32'h2000_0000;
    localparam logic [31:0] B0 = 32'h2000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we, dma_req, dma_we;
    logic [1:0]  cpu_size, dma_size;
    logic [31:0] cpu_addr, cpu_wdata, dma_addr, dma_wdata;
    logic        cpu_ready, cpu_fault, dma_ready, dma_fault;
    logic [31:0] cpu_rdata, dma_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dual_bank_sram i_dual_bank_sram (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_fault(cpu_fault), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_size(dma_size), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_ready(dma_ready), .dma_fault(dma_fault), .dma_rdata(dma_rdata)
    );

    typedef struct packed {
        logic        c_req; logic c_we; logic [1:0] c_sz; logic [31:0] c_addr; logic [31:0] c_wd;
        logic        d_req; logic d_we; logic [1:0] d_sz; logic [31:0] d_addr; logic [31:0] d_wd;
        logic        e_cr;  logic e_dr; logic e_cf; logic e_df;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1,1,2,A0,        32'h1122_3344, 1,1,2,B0,        32'hA5A5_5A5A, 1,1,0,0},
        '{1,0,2,A0,        32'h0,         1,0,2,B0,        32'h0,         1,1,0,0},
        '{1,1,0,A0+1,      32'h0000_BB00, 1,1,1,B0+2,      32'hCAFE_0000, 1,1,0,0},
        '{1,0,2,A0,        32'h0,         1,0,2,B0,        32'h0,         1,1,0,0},
        '{1,0,0,A0+2,      32'h0,         1,0,1,B0,        32'h0,         1,1,0,0},
        '{1,1,2,A0+8,      32'hDEAD_BEEF, 1,1,2,A0+12,     32'h0102_0304, 1,0,0,0},
        '{0,0,0,32'h0,     32'h0,         1,1,2,A0+12,     32'h0102_0304, 0,1,0,0},
        '{1,0,2,A0+12,     32'h0,         1,0,2,A0+8,      32'h0,         1,0,0,0},
        '{0,0,0,32'h0,     32'h0,         1,0,2,A0+8,      32'h0,         0,1,0,0},
        '{1,1,2,B0+4,      32'h5566_7788, 1,1,2,A0+16,     32'h99AA_BBCC, 1,1,0,0},
        '{1,0,2,A0+16,     32'h0,         1,0,2,B0+4,      32'h0,         1,1,0,0},
        '{1,1,1,A0+1,      32'hFFFF_FFFF, 1,1,2,B0+6,      32'hFFFF_FFFF, 1,1,1,1},
        '{1,0,2,A0,        32'h0,         1,0,2,B0+4,      32'h0,         1,1,0,0},
        '{1,1,3,A0,        32'hFFFF_FFFF, 1,0,2,A0+32'h180,32'h0,         1,1,1,1},
        '{1,0,2,32'h1FFF_FFFC,32'h0,      1,0,2,A0,        32'h0,         1,1,1,0},
        '{1,1,1,A0+3,      32'hFFFF_FFFF, 1,1,0,A0+3,      32'h7700_0000, 1,1,1,0},
        '{1,0,2,A0,        32'h0,         0,0,0,32'h0,     32'h0,         1,0,0,0},
        '{0,0,0,32'h0,     32'h0,         0,0,0,32'h0,     32'h0,         0,0,0,0},
        '{1,0,1,A0+2,      32'h0,         1,0,0,B0+3,      32'h0,         1,1,0,0},
        '{1,1,2,A0+32'hFC, 32'h0BAD_F00D, 1,1,2,B0+32'h7C, 32'h600D_CAFE, 1,1,0,0},
        '{1,0,2,B0+32'h7C, 32'h0,         1,0,2,A0+32'hFC, 32'h0,         1,1,0,0}
    };

    logic [7:0] mdl [384];

    function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [31:0] a);
        case (sz)
            2'd0:    return 4'b0001 << a[1:0];
            2'd1:    return 4'b0011 << a[1:0];
            2'd2:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] sz, input logic [31:0] a);
        logic [31:0] w = '0;
        logic [3:0]  m = lanes(sz, a);
        int          base = int'((a - A0) & 32'hFFFF_FFFC);
        for (int l = 0; l < 4; l++) if (m[l]) w[8*l +: 8] = mdl[base + l];
        return w;
    endfunction

    task automatic model_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        logic [3:0] m = lanes(sz, a);
        int         base = int'((a - A0) & 32'hFFFF_FFFC);
        for (int l = 0; l < 4; l++) if (m[l]) mdl[base + l] = d[8*l +: 8];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cpu_req = 0; cpu_we = 0; cpu_size = 0; cpu_addr = 0; cpu_wdata = 0;
        dma_req = 0; dma_we = 0; dma_size = 0; dma_addr = 0; dma_wdata = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] exp_c, exp_d;
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R8: under reset a request gets no ready and the read data is zero.
        cpu_req = 1; cpu_addr = A0; cpu_size = 2;
        dma_req = 1; dma_addr = B0 + 6; dma_size = 2;
        #1;
        check("R8 reset cpu_ready", 32'(cpu_ready), 32'h0);
        check("R8 reset dma_fault", 32'(dma_fault), 32'h0);
        @(negedge clk);
        check("R8 reset cpu_rdata", cpu_rdata, 32'h0);
        idle_inputs();
        rst_n = 1'b1;

        exp_c = '0; exp_d = '0;
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            // R7 R8 R2 R9: data of the previous cycle's reads, zero when none.
            check($sformatf("R7 R8 cpu_rdata v%0d", i), cpu_rdata, exp_c);
            check($sformatf("R7 R8 dma_rdata v%0d", i), dma_rdata, exp_d);
            if (i == NV) begin
                idle_inputs();
            end else begin
                cpu_req = VEC[i].c_req; cpu_we = VEC[i].c_we; cpu_size = VEC[i].c_sz;
                cpu_addr = VEC[i].c_addr; cpu_wdata = VEC[i].c_wd;
                dma_req = VEC[i].d_req; dma_we = VEC[i].d_we; dma_size = VEC[i].d_sz;
                dma_addr = VEC[i].d_addr; dma_wdata = VEC[i].d_wd;
                #1;
                // R4 R5 R6: same-cycle ready; R1 R3: fault flags.
                check($sformatf("R4 R5 R6 cpu_ready v%0d", i), 32'(cpu_ready), 32'(VEC[i].e_cr));
                check($sformatf("R4 R5 R6 dma_ready v%0d", i), 32'(dma_ready), 32'(VEC[i].e_dr));
                check($sformatf("R1 R3 cpu_fault v%0d", i), 32'(cpu_fault), 32'(VEC[i].e_cf));
                check($sformatf("R1 R3 dma_fault v%0d", i), 32'(dma_fault), 32'(VEC[i].e_df));
                exp_c = (VEC[i].e_cr && !VEC[i].e_cf && !VEC[i].c_we)
                        ? model_read(VEC[i].c_sz, VEC[i].c_addr) : 32'h0;
                exp_d = (VEC[i].e_dr && !VEC[i].e_df && !VEC[i].d_we)
                        ? model_read(VEC[i].d_sz, VEC[i].d_addr) : 32'h0;
                if (VEC[i].e_cr && !VEC[i].e_cf && VEC[i].c_we)
                    model_write(VEC[i].c_sz, VEC[i].c_addr, VEC[i].c_wd);
                if (VEC[i].e_dr && !VEC[i].e_df && VEC[i].d_we)
                    model_write(VEC[i].d_sz, VEC[i].d_addr, VEC[i].d_wd);
            end
        end

        // R6: a DMA write stays held while the CPU keeps bank A busy for three cycles.
        cpu_req = 1; cpu_we = 0; cpu_size = 2; cpu_addr = A0 + 4;
        dma_req = 1; dma_we = 1; dma_size = 0; dma_addr = A0 + 2; dma_wdata = 32'h0099_0000;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R6 held dma_ready", 32'(dma_ready), 32'h0);
            @(negedge clk);
        end
        cpu_req = 0;
        #1;
        check("R6 released dma_ready", 32'(dma_ready), 32'h1);
        model_write(2'd0, A0 + 2, 32'h0099_0000);
        @(negedge clk);
        idle_inputs();
        cpu_req = 1; cpu_size = 2; cpu_addr = A0;
        @(negedge clk);
        check("R6 R2 late write merged", cpu_rdata, model_read(2'd2, A0));
        check("R6 R2 late write value", cpu_rdata, 32'h7799_BB44);

        // R8: a synchronous reset in the cycle of a read drops its data and ready.
        cpu_req = 1; cpu_addr = A0; rst_n = 1'b0;
        #1;
        check("R8 reset blocks cpu_ready", 32'(cpu_ready), 32'h0);
        @(negedge clk);
        check("R8 reset clears cpu_rdata", cpu_rdata, 32'h0);
        idle_inputs();
        rst_n = 1'b1;
        @(negedge clk);
        // R9 R1: contents survive reset; last word of bank B read by the DMA port.
        dma_req = 1; dma_size = 2; dma_addr = B0 + 32'h7C;
        @(negedge clk);
        check("R9 R1 bank B top word", dma_rdata, 32'h600D_CAFE);
        idle_inputs();
        @(negedge clk);
        finish_run();
    end
endmodule